// File: doc/BRIEF.md
# TDM Receive Slot Router

This block receives one serial line of a time-division multiplexed audio frame with up to four data slots. It locates each frame from the rising edge of the frame sync, counts bits into words of 8 or 16 bits, and tracks which slot each word belongs to. Only words from slots enabled in the slot mask are kept. Words from all other slots are dropped.

Each kept word goes to exactly one of two places, chosen per slot. It goes either to a shared receive FIFO through a one-cycle write strobe, or to that slot's own DMA holding register, which has its own request line. The FIFO storage and the DMA engine are outside the block. The block sees the FIFO through its full flag and occupancy level. It sees each DMA engine through a per-slot read acknowledge. An interrupt reports when the FIFO occupancy rises above a programmable limit.

The block is clocked by the bit clock: serial data and frame sync are sampled on each rising edge.

Top module: `tdm_rx_router`

## Requirements
- R1: A frame starts on the clock edge where `frameSync` is sampled high after having been sampled low. The data bit sampled in that same cycle is the first bit of slot 0. If `frameSync` stays high for several bits (a long sync), the frame does not restart.
- R2: `wordIs16`=1 selects 16-bit words and `wordIs16`=0 selects 8-bit words. Bits arrive MSB first. A delivered word is right-justified in 16 bits, and in 8-bit mode its upper byte is zero.
- R3: A word received in slot i with `slotMask[i]`=0 produces no FIFO write, loads no DMA register and sets no flag.
- R4: A word received in slot i with `slotMask[i]`=1 and `dmaEnable[i]`=0 produces exactly one `fifoWrEn` pulse carrying that word, one cycle after its last bit is sampled. Words reach the FIFO in slot order.
- R5: A word received in slot i with `slotMask[i]`=1 and `dmaEnable[i]`=1 is loaded into slice i of `dmaData` (bits 16*i+15 down to 16*i) and never reaches the FIFO. `dmaReq[i]` rises at the same time.
- R6: A one-cycle pulse on `dmaRdAck[i]` clears `dmaReq[i]` and leaves the other request lines unchanged.
- R7: If a word arrives for DMA slot i while `dmaReq[i]` is still high, the register takes the new word and `dmaOverrun[i]` is set. The flag stays set until reset.
- R8: If a FIFO-bound word completes while `fifoFull` is high, the word is dropped with no `fifoWrEn` pulse and `fifoOverflow` is set. The flag stays set until reset.
- R9: `irq` is high exactly when `fifoLevel`, sampled on the previous clock edge, is strictly greater than `warnLimit`.
- R10: Bits that follow the last slot of a frame, up to the next frame start, are ignored.
- R11: While reset is active, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; data and sync sampled on rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | Frame sync; rising edge marks slot 0 bit 0 |
| serData | input | 1 | Serial receive data, MSB first |
| slotMask | input | 4 | Per-slot enable; 1 keeps words of that slot |
| dmaEnable | input | 4 | Per-slot destination; 1 = DMA register, 0 = FIFO |
| wordIs16 | input | 1 | Word length select: 1 = 16 bits, 0 = 8 bits |
| warnLimit | input | 6 | FIFO occupancy threshold for the interrupt |
| fifoLevel | input | 6 | Current FIFO occupancy |
| fifoFull | input | 1 | FIFO cannot accept a write |
| fifoWrEn | output | 1 | One-cycle FIFO write strobe |
| fifoWrData | output | 16 | Word written to the FIFO |
| dmaData | output | 64 | Four 16-bit DMA holding registers, slot i at bits 16*i+15:16*i |
| dmaReq | output | 4 | Per-slot DMA request, high while register is full |
| dmaRdAck | input | 4 | Per-slot read acknowledge from the DMA engine |
| dmaOverrun | output | 4 | Sticky per-slot overrun flags |
| fifoOverflow | output | 1 | Sticky FIFO overflow flag |
| irq | output | 1 | FIFO occupancy above warning limit |

## Verification
The most sensitive internal state is the bit and slot counters. If either is off by one, words come out shifted by a bit or land in the neighbouring slot. That shows up as a wrong `fifoWrData` value or a wrong `dmaData` slice in the first frame, one cycle after the affected word's last bit. A wrong routing decision shows as a missing or extra FIFO write, or as a request on the wrong line, within that same cycle. A lost full flag or a sticky flag that clears early shows on `dmaReq`, `dmaOverrun` or `fifoOverflow` by the next frame at the latest.

// File: rtl/tdmrx_pkg.sv
package tdmrx_pkg;
  // Slot index width: holds slot numbers plus one "idle" code past the last slot.
  localparam int SLOT_W = 3;

  // Strobes handed from the frame controller to the datapath each bit cycle.
  typedef struct packed {
    logic              wordDone;  // the bit sampled this cycle completes a word
    logic [SLOT_W-1:0] slot;      // slot owning that word
  } rxStrobe_t;
endpackage

// File: rtl/tdmrx_ctrl.sv
module tdmrx_ctrl
  import tdmrx_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int MAX_BITS  = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameSync,
  input  logic      wordIs16,
  output rxStrobe_t strobe
);
  localparam int BIT_W = $clog2(MAX_BITS);
  localparam logic [BIT_W-1:0]  LAST_LONG  = BIT_W'(MAX_BITS - 1);
  localparam logic [BIT_W-1:0]  LAST_SHORT = BIT_W'(MAX_BITS / 2 - 1);
  localparam logic [SLOT_W-1:0] IDLE_SLOT  = SLOT_W'(NUM_SLOTS);

  logic              fsPrev;
  logic [BIT_W-1:0]  bitCnt;
  logic [SLOT_W-1:0] slotCnt;

  logic              fsRise;
  logic [BIT_W-1:0]  effBit;
  logic [SLOT_W-1:0] effSlot;
  logic              inFrame;
  logic [BIT_W-1:0]  lastBit;
  logic              wordDone;

  always_comb begin
    fsRise   = frameSync & ~fsPrev;
    effBit   = fsRise ? '0 : bitCnt;
    effSlot  = fsRise ? '0 : slotCnt;
    inFrame  = effSlot < IDLE_SLOT;
    lastBit  = wordIs16 ? LAST_LONG : LAST_SHORT;
    wordDone = inFrame && (effBit == lastBit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsPrev  <= 1'b0;
      bitCnt  <= '0;
      slotCnt <= IDLE_SLOT;
    end else begin
      fsPrev <= frameSync;
      if (inFrame) begin
        if (wordDone) begin
          bitCnt  <= '0;
          slotCnt <= effSlot + SLOT_W'(1);
        end else begin
          bitCnt  <= effBit + BIT_W'(1);
          slotCnt <= effSlot;
        end
      end
    end
  end

  assign strobe.wordDone = wordDone;
  assign strobe.slot     = effSlot;
endmodule

// File: rtl/tdmrx_datapath.sv
module tdmrx_datapath
  import tdmrx_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int MAX_BITS  = 16,
  parameter int LVL_W     = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          serData,
  input  rxStrobe_t                     strobe,
  input  logic                          wordIs16,
  input  logic [NUM_SLOTS-1:0]          slotMask,
  input  logic [NUM_SLOTS-1:0]          dmaEnable,
  input  logic [LVL_W-1:0]              warnLimit,
  input  logic [LVL_W-1:0]              fifoLevel,
  input  logic                          fifoFull,
  input  logic [NUM_SLOTS-1:0]          dmaRdAck,
  output logic                          fifoWrEn,
  output logic [MAX_BITS-1:0]           fifoWrData,
  output logic [NUM_SLOTS*MAX_BITS-1:0] dmaData,
  output logic [NUM_SLOTS-1:0]          dmaReq,
  output logic [NUM_SLOTS-1:0]          dmaOverrun,
  output logic                          fifoOverflow,
  output logic                          irq
);
  localparam int HALF = MAX_BITS / 2;

  logic [MAX_BITS-2:0]  shReg;
  logic [MAX_BITS-1:0]  rawWord;
  logic [MAX_BITS-1:0]  word;
  logic [NUM_SLOTS-1:0] slotHit;
  logic [NUM_SLOTS-1:0] dmaHit;
  logic                 fifoHit;

  // Shift register; the current bit completes the word combinationally.
  always_ff @(posedge clk) begin
    if (!rstN) shReg <= '0;
    else       shReg <= {shReg[MAX_BITS-3:0], serData};
  end

  always_comb begin
    rawWord = {shReg, serData};
    word    = wordIs16 ? rawWord : {{(MAX_BITS-HALF){1'b0}}, rawWord[HALF-1:0]};
  end

  // Per-slot decode and DMA holding registers.
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : gSlot
    logic [MAX_BITS-1:0] holdReg;
    logic                fullFlag;
    logic                ovrFlag;

    assign slotHit[i] = strobe.wordDone && (strobe.slot == SLOT_W'(i)) && slotMask[i];
    assign dmaHit[i]  = slotHit[i] & dmaEnable[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        holdReg  <= '0;
        fullFlag <= 1'b0;
        ovrFlag  <= 1'b0;
      end else if (dmaHit[i]) begin
        holdReg  <= word;
        fullFlag <= 1'b1;
        if (fullFlag && !dmaRdAck[i]) ovrFlag <= 1'b1;
      end else if (dmaRdAck[i]) begin
        fullFlag <= 1'b0;
      end
    end

    assign dmaData[i*MAX_BITS +: MAX_BITS] = holdReg;
    assign dmaReq[i]     = fullFlag;
    assign dmaOverrun[i] = ovrFlag;
  end

  assign fifoHit = |(slotHit & ~dmaEnable);

  // FIFO write port and sticky overflow.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoWrEn     <= 1'b0;
      fifoWrData   <= '0;
      fifoOverflow <= 1'b0;
    end else begin
      fifoWrEn <= fifoHit && !fifoFull;
      if (fifoHit && !fifoFull) fifoWrData <= word;
      if (fifoHit && fifoFull)  fifoOverflow <= 1'b1;
    end
  end

  // Occupancy warning.
  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= fifoLevel > warnLimit;
  end
endmodule

// File: rtl/tdm_rx_router.sv
module tdm_rx_router
  import tdmrx_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int MAX_BITS  = 16,
  parameter int LVL_W     = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          frameSync,
  input  logic                          serData,
  input  logic [NUM_SLOTS-1:0]          slotMask,
  input  logic [NUM_SLOTS-1:0]          dmaEnable,
  input  logic                          wordIs16,
  input  logic [LVL_W-1:0]              warnLimit,
  input  logic [LVL_W-1:0]              fifoLevel,
  input  logic                          fifoFull,
  output logic                          fifoWrEn,
  output logic [MAX_BITS-1:0]           fifoWrData,
  output logic [NUM_SLOTS*MAX_BITS-1:0] dmaData,
  output logic [NUM_SLOTS-1:0]          dmaReq,
  input  logic [NUM_SLOTS-1:0]          dmaRdAck,
  output logic [NUM_SLOTS-1:0]          dmaOverrun,
  output logic                          fifoOverflow,
  output logic                          irq
);
  rxStrobe_t strobe;

  tdmrx_ctrl #(.NUM_SLOTS(NUM_SLOTS), .MAX_BITS(MAX_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .wordIs16(wordIs16), .strobe(strobe)
  );

  tdmrx_datapath #(.NUM_SLOTS(NUM_SLOTS), .MAX_BITS(MAX_BITS), .LVL_W(LVL_W)) uPath (
    .clk(clk), .rstN(rstN), .serData(serData), .strobe(strobe), .wordIs16(wordIs16),
    .slotMask(slotMask), .dmaEnable(dmaEnable), .warnLimit(warnLimit),
    .fifoLevel(fifoLevel), .fifoFull(fifoFull), .dmaRdAck(dmaRdAck),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData), .dmaData(dmaData), .dmaReq(dmaReq),
    .dmaOverrun(dmaOverrun), .fifoOverflow(fifoOverflow), .irq(irq)
  );
endmodule

// File: rtl/tdmrx_checker.sv
module tdmrx_checker #(
  parameter int NUM_SLOTS = 4,
  parameter int LVL_W     = 6
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 fifoFull,
  input logic                 fifoWrEn,
  input logic                 fifoOverflow,
  input logic                 irq,
  input logic [LVL_W-1:0]     fifoLevel,
  input logic [LVL_W-1:0]     warnLimit,
  input logic [NUM_SLOTS-1:0] slotMask,
  input logic [NUM_SLOTS-1:0] dmaEnable,
  input logic [NUM_SLOTS-1:0] dmaReq,
  input logic [NUM_SLOTS-1:0] dmaRdAck,
  input logic [NUM_SLOTS-1:0] dmaOverrun
);
  AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> !$past(fifoFull));  // R8

  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    fifoOverflow |=> fifoOverflow);  // R8

  AST_IRQ_THRESHOLD: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (irq == ($past(fifoLevel) > $past(warnLimit))));  // R9

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : gChk
    AST_REQ_ONLY_DMA_SLOT: assert property (@(posedge clk) disable iff (!rstN)
      $rose(dmaReq[i]) |-> $past(dmaEnable[i] & slotMask[i]));  // R5

    AST_REQ_CLEARED_BY_ACK: assert property (@(posedge clk) disable iff (!rstN)
      $fell(dmaReq[i]) |-> $past(dmaRdAck[i]));  // R6

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      dmaOverrun[i] |=> dmaOverrun[i]);  // R7
  end
endmodule

bind tdm_rx_router tdmrx_checker #(.NUM_SLOTS(NUM_SLOTS), .LVL_W(LVL_W)) uChk (
  .clk(clk), .rstN(rstN), .fifoFull(fifoFull), .fifoWrEn(fifoWrEn),
  .fifoOverflow(fifoOverflow), .irq(irq), .fifoLevel(fifoLevel), .warnLimit(warnLimit),
  .slotMask(slotMask), .dmaEnable(dmaEnable), .dmaReq(dmaReq), .dmaRdAck(dmaRdAck),
  .dmaOverrun(dmaOverrun)
);

// File: tb/tdm_rx_router_test.sv
`timescale 1ns/1ps
module tdm_rx_router_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameSync = 1'b0;
  logic        serData = 1'b0;
  logic [3:0]  slotMask = '0;
  logic [3:0]  dmaEnable = '0;
  logic        wordIs16 = 1'b0;
  logic [5:0]  warnLimit = '0;
  logic [5:0]  fifoLevel = '0;
  logic        fifoFull = 1'b0;
  logic        fifoWrEn;
  logic [15:0] fifoWrData;
  logic [63:0] dmaData;
  logic [3:0]  dmaReq;
  logic [3:0]  dmaRdAck = '0;
  logic [3:0]  dmaOverrun;
  logic        fifoOverflow;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  logic [15:0] wrLog [0:15];
  int wrCount = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tdm_rx_router uut (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .serData(serData),
    .slotMask(slotMask), .dmaEnable(dmaEnable), .wordIs16(wordIs16),
    .warnLimit(warnLimit), .fifoLevel(fifoLevel), .fifoFull(fifoFull),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData), .dmaData(dmaData), .dmaReq(dmaReq),
    .dmaRdAck(dmaRdAck), .dmaOverrun(dmaOverrun), .fifoOverflow(fifoOverflow), .irq(irq)
  );

  // FIFO write monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rstN && fifoWrEn) begin
      if (wrCount < 16) wrLog[wrCount] = fifoWrData;
      wrCount++;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0; frameSync = 1'b0; serData = 1'b0; dmaRdAck = '0; fifoFull = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    wrCount = 0;
  endtask

  // Drives one frame of four slots, then tailBits of ones with sync low.
  task automatic sendFrame(input logic [3:0][15:0] words, input bit is16,
                           input int syncLen, input int tailBits);
    int nb = is16 ? 16 : 8;
    int idx = 0;
    for (int s = 0; s < 4; s++) begin
      for (int b = nb - 1; b >= 0; b--) begin
        @(negedge clk);
        frameSync = (idx < syncLen);
        serData   = words[s][b];
        idx++;
      end
    end
    for (int t = 0; t < tailBits; t++) begin
      @(negedge clk);
      frameSync = 1'b0;
      serData   = 1'b1;
    end
    @(negedge clk);
    frameSync = 1'b0; serData = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    rstN = 1'b0;
    fifoLevel = 6'd9; warnLimit = 6'd1;
    repeat (3) @(negedge clk);
    check("R11 fifoWrEn in reset", fifoWrEn, 0);
    check("R11 dmaReq in reset", dmaReq, 0);
    check("R11 flags in reset", {dmaOverrun, fifoOverflow, irq}, 0);
    check("R11 dmaData in reset", dmaData, 0);
    fifoLevel = 0; warnLimit = 0;
    applyReset();
  endtask

  task automatic testFifo8();
    applyReset();
    slotMask = 4'b1111; dmaEnable = 4'b0000; wordIs16 = 1'b0;
    sendFrame({16'h000F, 16'h00F0, 16'h003C, 16'h00A5}, 1'b0, 1, 4);
    check("R4 fifo write count, 8-bit", wrCount, 4);
    check("R2 R4 slot0 word zero-padded", wrLog[0], 16'h00A5);
    check("R4 slot1 word", wrLog[1], 16'h003C);
    check("R4 slot2 word", wrLog[2], 16'h00F0);
    check("R1 R4 slot3 word", wrLog[3], 16'h000F);
    check("R5 no DMA request for FIFO slots", dmaReq, 0);
  endtask

  task automatic testMaskLong16();
    applyReset();
    slotMask = 4'b0101; dmaEnable = 4'b0000; wordIs16 = 1'b1;
    sendFrame({16'h0F0F, 16'hCAFE, 16'h1234, 16'hBEEF}, 1'b1, 5, 20);
    check("R3 R10 only masked-in slots written", wrCount, 2);
    check("R1 R2 long sync slot0 16-bit", wrLog[0], 16'hBEEF);
    check("R3 slot2 after skipped slot1", wrLog[1], 16'hCAFE);
    check("R3 no flags from dropped slots", {dmaReq, dmaOverrun, fifoOverflow}, 0);
  endtask

  task automatic testDma();
    applyReset();
    slotMask = 4'b1111; dmaEnable = 4'b0110; wordIs16 = 1'b0;
    sendFrame({16'h0044, 16'h0033, 16'h0022, 16'h0011}, 1'b0, 2, 3);
    check("R5 FIFO gets only non-DMA slots", wrCount, 2);
    check("R5 FIFO first word", wrLog[0], 16'h0011);
    check("R5 FIFO second word", wrLog[1], 16'h0044);
    check("R5 DMA slot1 data", dmaData[31:16], 16'h0022);
    check("R5 DMA slot2 data", dmaData[47:32], 16'h0033);
    check("R5 request lines", dmaReq, 4'b0110);
    @(negedge clk); dmaRdAck = 4'b0010;
    @(negedge clk); dmaRdAck = 4'b0000;
    check("R6 ack clears only slot1 request", dmaReq, 4'b0100);
    wrCount = 0;
    sendFrame({16'h0088, 16'h0077, 16'h0066, 16'h0055}, 1'b0, 1, 3);
    check("R7 overrun only on unread slot", dmaOverrun, 4'b0100);
    check("R7 overrun register takes new word", dmaData[47:32], 16'h0077);
    check("R5 reloaded slot1 data", dmaData[31:16], 16'h0066);
    check("R5 R6 requests after second frame", dmaReq, 4'b0110);
    repeat (3) @(negedge clk);
    check("R7 overrun flag sticky", dmaOverrun, 4'b0100);
  endtask

  task automatic testOverflow();
    applyReset();
    slotMask = 4'b0011; dmaEnable = 4'b0000; wordIs16 = 1'b0;
    fifoFull = 1'b1;
    sendFrame({16'h0004, 16'h0003, 16'h0002, 16'h0001}, 1'b0, 1, 2);
    check("R8 no write while FIFO full", wrCount, 0);
    check("R8 overflow flag set", fifoOverflow, 1);
    fifoFull = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 overflow flag sticky", fifoOverflow, 1);
  endtask

  task automatic testIrq();
    applyReset();
    warnLimit = 6'd5; fifoLevel = 6'd5;
    repeat (2) @(negedge clk);
    check("R9 irq low at level equal limit", irq, 0);
    fifoLevel = 6'd6;
    @(negedge clk);
    check("R9 irq one cycle after level above limit", irq, 1);
    fifoLevel = 6'd0;
    @(negedge clk);
    check("R9 irq drops with level", irq, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    testReset();
    testFifo8();
    testMaskLong16();
    testDma();
    testOverflow();
    testIrq();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule